// File: doc/BRIEF.md
# Dual-Input Capture Timer

This block contains a 16-bit counter that runs without stopping and two external capture inputs. It can time two independent pulse trains at once. Each input passes through a two-flop synchronizer and then a noise filter that samples on the count clock. A new level is accepted only when two consecutive count-clock samples agree. When an accepted level change matches the edge mode chosen for that input, the current counter value is copied into a capture register and a one-cycle interrupt request is raised. The routing is crossed. Input 0 loads capture register 1 and raises request 1. Input 1 loads capture register 0 and raises request 0.

Software sets the prescaler and the two edge modes with a write port. Reading two capture values and subtracting them gives a pulse width or a period in count-clock ticks. A sticky flag records that the counter has wrapped, so software can correct for the wrap. The counter is never cleared by a capture.

Top module: `capTimer`

## Requirements
- R1: While `rstN` is low, `count`, `capture0`, `capture1`, `irq0`, `irq1` and `ovfFlag` are all 0, and the filtered level of each input is 0.
- R2: `count` advances by exactly one on each count tick, holds otherwise, wraps from FFFFh to 0000h, and is never changed by a capture.
- R3: Config bits 1:0 select the count tick. 00 gives every system clock, 01 gives one clock in 4, 10 gives one clock in 16. With 11 there are no ticks: the counter holds and the inputs are not sampled.
- R4: An accepted edge on `capIn[0]` loads the pre-edge `count` value into `capture1` and raises `irq1` for exactly one system clock.
- R5: An accepted edge on `capIn[1]` loads the pre-edge `count` value into `capture0` and raises `irq0` for exactly one system clock.
- R6: Config bits 5:4 set the edge mode of `capIn[0]`, and bits 7:6 set the edge mode of `capIn[1]`. The codes are 00 falling, 01 rising, 10 no capture, 11 both edges.
- R7: On each count tick the synchronized input is sampled. The filtered level changes only when the current sample equals the previous sample and differs from the filtered level. A level shorter than two samples is rejected.
- R8: `ovfFlag` is set on the tick that wraps `count` from FFFFh to 0. It then stays set until it is cleared. If a set and a clear happen in the same cycle, the set wins.
- R9: A write with `wrAddr`=0 loads the config byte. A write with `wrAddr`=1 clears `ovfFlag` and leaves the config unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0: config byte, 1: clear overflow |
| wrData | input | 8 | Write data |
| capIn | input | 2 | Raw asynchronous capture inputs |
| count | output | 16 | Free-running counter value |
| capture0 | output | 16 | Capture register loaded by input 1 |
| capture1 | output | 16 | Capture register loaded by input 0 |
| irq0 | output | 1 | Capture request from input 1 |
| irq1 | output | 1 | Capture request from input 0 |
| ovfFlag | output | 1 | Sticky counter-wrap flag |

## Verification
The bench applies dense input toggling, including single-clock glitches, and compares every output against a behavioural model on every clock. A design that does not cross the routing writes the wrong capture register. A filter that needs only one sample lets glitches through. A filter that samples on the system clock instead of the count tick gives wrong capture values at the divided rates. Separate runs check that the reserved edge mode leaves the capture register unchanged. They also check that prescaler code 11 freezes the counter, that the other codes give the exact tick count over a fixed window, and that the overflow flag is set on the wrap and cleared only by a write to address 1.

// File: rtl/capTimerPkg.sv
package capTimerPkg;

  typedef enum logic [1:0] {
    PSC_DIV1 = 2'b00,
    PSC_DIVA = 2'b01,
    PSC_DIVB = 2'b10,
    PSC_HOLD = 2'b11
  } pscE;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic loadCap0;
    logic loadCap1;
    logic clrOvf;
  } strobesT;

endpackage

// File: rtl/capInputFilter.sv
module capInputFilter (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  logic rawIn,
  output logic rise,
  output logic fall
);

  logic syncA, syncB, prevQ, filtQ;
  logic accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  assign accept = sampleEn && (syncB == prevQ) && (syncB != filtQ);
  assign rise   = accept && syncB;
  assign fall   = accept && !syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      filtQ <= 1'b0;
    end else if (sampleEn) begin
      prevQ <= syncB;
      if (accept) filtQ <= syncB;
    end
  end

  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(filtQ)); // R7

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (rise || fall) |=> !(rise || fall)); // R7

endmodule

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
#(
  parameter int DIV_LOG_A = 2,
  parameter int DIV_LOG_B = 4,
  parameter int NUM_IN    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [7:0]        wrData,
  input  logic [NUM_IN-1:0] capIn,
  output strobesT           strobes
);

  localparam int SEL_BASE = 4;

  pscE         pscQ;
  edgeSelE     edgeSelQ [NUM_IN];
  logic [DIV_LOG_B-1:0] divCnt;
  logic        tick;
  logic [NUM_IN-1:0] riseS, fallS, hit;
  logic        unusedCfgBits;

  assign unusedCfgBits = ^wrData[3:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscQ <= PSC_DIV1;
      for (int i = 0; i < NUM_IN; i++) edgeSelQ[i] <= EDGE_FALL;
    end else if (wrEn && !wrAddr) begin
      pscQ <= pscE'(wrData[1:0]);
      for (int i = 0; i < NUM_IN; i++)
        edgeSelQ[i] <= edgeSelE'(wrData[SEL_BASE + 2*i +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    unique case (pscQ)
      PSC_DIV1: tick = 1'b1;
      PSC_DIVA: tick = &divCnt[DIV_LOG_A-1:0];
      PSC_DIVB: tick = &divCnt;
      default:  tick = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : gIn
    capInputFilter u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .sampleEn (tick),
      .rawIn    (capIn[i]),
      .rise     (riseS[i]),
      .fall     (fallS[i])
    );
    assign hit[i] = (edgeSelQ[i] == EDGE_BOTH) ? (riseS[i] | fallS[i]) :
                    (edgeSelQ[i] == EDGE_RISE) ? riseS[i] :
                    (edgeSelQ[i] == EDGE_FALL) ? fallS[i] : 1'b0;
  end

  // crossed routing: input 0 -> register 1, input 1 -> register 0
  always_comb begin
    strobes.tick     = tick;
    strobes.loadCap1 = hit[0];
    strobes.loadCap0 = hit[1];
    strobes.clrOvf   = wrEn && wrAddr;
  end

  AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (pscQ == PSC_HOLD) |-> !(strobes.loadCap0 || strobes.loadCap1)); // R3

endmodule

// File: rtl/capTimerData.sv
module capTimerData
  import capTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobesT          strobes,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] cap0Q,
  output logic [CNT_W-1:0] cap1Q,
  output logic             irq0Q,
  output logic             irq1Q,
  output logic             ovfQ
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else if (strobes.tick) countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap0Q <= '0;
      cap1Q <= '0;
      irq0Q <= 1'b0;
      irq1Q <= 1'b0;
    end else begin
      irq0Q <= strobes.loadCap0;
      irq1Q <= strobes.loadCap1;
      if (strobes.loadCap0) cap0Q <= countQ;
      if (strobes.loadCap1) cap1Q <= countQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfQ <= 1'b0;
    else if (strobes.tick && countQ == CNT_MAX) ovfQ <= 1'b1;
    else if (strobes.clrOvf) ovfQ <= 1'b0;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |=> countQ == $past(countQ) + 1'b1); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> $stable(countQ)); // R2

  AST_CAP1_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq1Q) |-> cap1Q == $past(countQ)); // R4

  AST_CAP0_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq0Q) |-> cap0Q == $past(countQ)); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (irq0Q || irq1Q) |=> !(irq0Q && $past(irq0Q)) && !(irq1Q && $past(irq1Q))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !strobes.clrOvf) |=> ovfQ); // R8

endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIV_LOG_A = 2,
  parameter int DIV_LOG_B = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [7:0]       wrData,
  input  logic [1:0]       capIn,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture0,
  output logic [CNT_W-1:0] capture1,
  output logic             irq0,
  output logic             irq1,
  output logic             ovfFlag
);

  strobesT strobes;

  capTimerCtrl #(
    .DIV_LOG_A (DIV_LOG_A),
    .DIV_LOG_B (DIV_LOG_B),
    .NUM_IN    (2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .capIn   (capIn),
    .strobes (strobes)
  );

  capTimerData #(
    .CNT_W (CNT_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .countQ  (count),
    .cap0Q   (capture0),
    .cap1Q   (capture1),
    .irq0Q   (irq0),
    .irq1Q   (irq1),
    .ovfQ    (ovfFlag)
  );

endmodule

// File: tb/test_capTimer.sv
module test_capTimer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [1:0]  capIn = 2'b00;
  logic [15:0] count, capture0, capture1;
  logic        irq0, irq1, ovfFlag;

  int nChecks = 0;
  int nFails  = 0;
  int irq0Seen = 0;
  int irq1Seen = 0;
  bit finished = 0;

  // behavioural reference model state
  int mS1[2], mS2[2], mPrev[2], mFilt[2];
  int mCfg, mDiv, mCnt, mCap0, mCap1, mIrq0, mIrq1, mOvf;
  bit modelLive = 0;

  always #2 clk = ~clk;

  capTimer i_capTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .capIn(capIn), .count(count), .capture0(capture0), .capture1(capture1),
    .irq0(irq0), .irq1(irq1), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mS1[i] = 0; mS2[i] = 0; mPrev[i] = 0; mFilt[i] = 0;
      end
      mCfg = 0; mDiv = 0; mCnt = 0; mCap0 = 0; mCap1 = 0;
      mIrq0 = 0; mIrq1 = 0; mOvf = 0;
      modelLive = 1;
    end else begin
      int psc;
      bit tick;
      bit hit[2];
      psc = mCfg & 3;
      tick = (psc == 0) || (psc == 1 && mDiv % 4 == 3) || (psc == 2 && mDiv % 16 == 15);
      for (int i = 0; i < 2; i++) begin
        hit[i] = 0;
        if (tick) begin
          if (mS2[i] == mPrev[i] && mS2[i] != mFilt[i]) begin
            int sel;
            sel = (mCfg >> (4 + 2 * i)) & 3;
            hit[i] = (sel == 3) || (sel == 1 && mS2[i] == 1) || (sel == 0 && mS2[i] == 0);
            mFilt[i] = mS2[i];
          end
          mPrev[i] = mS2[i];
        end
        mS2[i] = mS1[i];
        mS1[i] = capIn[i];
      end
      mIrq1 = hit[0];
      mIrq0 = hit[1];
      if (hit[0]) mCap1 = mCnt;
      if (hit[1]) mCap0 = mCnt;
      if (wrEn && wrAddr) mOvf = 0;
      if (tick) begin
        if (mCnt == 65535) mOvf = 1;
        mCnt = (mCnt + 1) % 65536;
      end
      if (wrEn && !wrAddr) mCfg = wrData;
      mDiv = (mDiv + 1) % 16;
    end
  end

  always @(negedge clk) begin
    if (rstN && modelLive) begin
      check("R2/R3 count", count, mCnt);
      check("R5 capture0", capture0, mCap0);
      check("R4 capture1", capture1, mCap1);
      check("R5 irq0", irq0, mIrq0);
      check("R4 irq1", irq1, mIrq1);
      check("R8 ovfFlag", ovfFlag, mOvf);
      if (irq0) irq0Seen++;
      if (irq1) irq1Seen++;
    end
  end

  task automatic writeReg(input bit addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    int c0, s0, b0;
    lfsr = 16'hACE1;
    idle(4);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 capture0", capture0, 0);
    check("R1 capture1", capture1, 0);
    check("R1 irqs", {irq0, irq1}, 0);
    check("R1 ovfFlag", ovfFlag, 0);
    @(negedge clk) rstN = 1'b1;

    // both edges, divide by 1, random toggling with glitches
    writeReg(0, 8'hF0);
    for (int psc = 0; psc < 3; psc++) begin
      writeReg(0, 8'hF0 | psc);
      repeat (3000) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[3:0] == 4'h0) capIn[0] = ~capIn[0];
        if (lfsr[7:4] == 4'h1) capIn[1] = ~capIn[1];
      end
    end
    // mixed edge modes: input0 rising only, input1 falling only
    writeReg(0, 8'h10);
    repeat (2000) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'h0) capIn[0] = ~capIn[0];
      if (lfsr[5:3] == 3'h2) capIn[1] = ~capIn[1];
    end
    capIn = 2'b00;
    idle(10);

    // R7: single-clock glitch rejected at divide by 1
    writeReg(0, 8'hF0);
    idle(10);
    s0 = irq1Seen;
    @(negedge clk) capIn[0] = 1'b1;
    @(negedge clk) capIn[0] = 1'b0;
    idle(12);
    check("R7 glitch rejected", irq1Seen - s0, 0);
    // R7: held level accepted exactly once
    @(negedge clk) capIn[0] = 1'b1;
    idle(12);
    check("R7 held level accepted", irq1Seen - s0, 1);

    // R6: reserved mode on input 0 leaves capture1 unchanged
    writeReg(0, 8'hE0);
    idle(4);
    c0 = capture1; s0 = irq1Seen;
    @(negedge clk) capIn[0] = 1'b0;
    idle(12);
    @(negedge clk) capIn[0] = 1'b1;
    idle(12);
    check("R6 reserved no capture", capture1, c0);
    check("R6 reserved no irq", irq1Seen - s0, 0);
    // R6: rising only on input 1 counts one edge of a full pulse
    writeReg(0, 8'h70);
    idle(4);
    b0 = irq0Seen;
    @(negedge clk) capIn[1] = 1'b1;
    idle(12);
    @(negedge clk) capIn[1] = 1'b0;
    idle(12);
    check("R6 rising only", irq0Seen - b0, 1);

    // R3: prescaler rates
    writeReg(0, 8'h01);
    idle(4);
    c0 = count; idle(40);
    check("R3 divide by 4", (count - c0) & 16'hFFFF, 10);
    writeReg(0, 8'h02);
    idle(20);
    c0 = count; idle(160);
    check("R3 divide by 16", (count - c0) & 16'hFFFF, 10);
    writeReg(0, 8'hF3);
    idle(4);
    c0 = count; s0 = irq1Seen + irq0Seen;
    capIn = ~capIn;
    idle(50);
    check("R3 hold counter", count, c0);
    check("R3 hold no sampling", irq1Seen + irq0Seen - s0, 0);

    // R8/R9: wrap to overflow, then clear by address 1
    writeReg(0, 8'hF0);
    while (!(count == 16'hFFF0)) @(negedge clk);
    check("R8 no flag before wrap", ovfFlag, 0);
    idle(20);
    check("R8 flag after wrap", ovfFlag, 1);
    idle(5);
    check("R8 flag sticky", ovfFlag, 1);
    writeReg(1, 8'h00);
    check("R9 clear by address 1", ovfFlag, 0);
    c0 = count; idle(8);
    check("R9 config unchanged by clear", (count - c0) & 16'hFFFF, 8);

    finished = 1;
    summary();
  end

endmodule